// File: doc/BRIEF.md
# PLL Clock-Mode Transition Sequencer

This block walks a clock generator from its power-up state (frequency-locked loop on the internal reference) to a state where the phase-locked loop drives the system clock. The stages in between are external-reference bypass and PLL bypass. One request carries all of the settings: the external reference frequency in Hz, a gain select, an external-reference-is-crystal flag, the PLL pre-divider, the PLL multiplier and an engage flag. The block first checks the settings against fixed limits. It then derives the register field encodings and issues a fixed series of control-register writes on a one-way write port. Between writes it polls status inputs, and each poll has a bounded number of attempts. It reports either the resulting clock frequency or a single 8-bit error code.

The request side is a valid/ready stream. `req_ready` is high only while the sequencer is idle. A request is taken in the cycle where `req_valid` and `req_ready` are both high, and the settings only need to be stable in that cycle. A `req_valid` seen while `req_ready` is low is not held or queued. It is dropped, and the caller must present it again once ready returns. The result side has no back-pressure. `done` is a one-cycle pulse, and the caller captures `res_code` and `res_freq` with it.

The oscillator, the PLL and the clock multiplexers lie outside the block. They are visible only through the `st_*` status inputs.

Top module: `pll_mode_sequencer`

## Requirements
- R1: `req_ready` is 1 exactly when the sequencer is idle, including out of reset. A request is accepted only on `req_valid && req_ready`. `req_valid` pulses during a sequence change neither the writes nor the result of that sequence.
- R2: In the cycle after acceptance, the block requires `st_clk == 0`, `st_iref == 1` and `st_pllsel == 0`. If any of these does not hold, the sequence finishes with code 0x01 and makes no writes.
- R3: A frequency above 50,000,000 Hz gives code 0x21. When the crystal flag is 1, a frequency below 3,000,000 or above 32,000,000 gives code 0x22.
- R4: A pre-divider outside 1..25 gives code 0x41, and a multiplier outside 24..55 gives code 0x42. Any nonzero gain select is written as gain bit 1.
- R5: The reference check fails with 0x43 unless 2e6·P ≤ F ≤ 4e6·P. The PLL check fails with 0x45 unless 48e6·P ≤ F·M ≤ 100e6·P. Checks run in the order R2, R3, R4, R5, and only the first failure is reported.
- R6: Write selector values are 0 = source register, 1 = oscillator register, 2 = pre-divider register and 3 = PLL register. The writes go in this order: oscillator, source, PLL (monitor), pre-divider, PLL (select), then source again only if engage is set. Every write is a read-modify-write of a shadow copy, so unmentioned bits keep their last written value. Shadow reset values are 0x04 for the source register and 0 for the others.
- R7: The oscillator write sets bits [5:4] to range (1 if F ≤ 3,000,000, else 2), bit 3 to gain and bit 2 to the crystal flag. The first source write sets [7:6] to 2, [5:3] to the FLL divider code and bit 2 to 0. The divider code is 0 if F ≤ 1.25e6, 1 if F ≤ 2.5e6, 2 if F ≤ 5e6, 3 if F ≤ 10e6, 4 if F ≤ 20e6, and 5 otherwise.
- R8: With the crystal flag set, `st_osc_ready` is polled up to OSC_POLLS times, and a timeout gives 0x23. Then `st_clk == 2` is polled up to STEP_POLLS times, and a timeout gives 0x1A.
- R9: The monitor write sets PLL-register bit 5. The pre-divider write puts P−1 in bits [4:0]. The select write sets bit 7 and puts M−24 in bits [4:0].
- R10: `st_pllsel` is polled up to STEP_POLLS times (timeout 0x16). Then `st_lock` is polled up to STEP_POLLS times (timeout 0x44).
- R11: With engage set, the final source write clears [7:6], and `st_clk == 3` is polled up to STEP_POLLS times (timeout 0x1B). With engage clear, the sequence ends successfully once lock is seen.
- R12: `done` pulses for one cycle with exactly one of `res_ok`/`res_err`. On success `res_code` is 0 and `res_freq = floor(F / (pdiv_field+1)) × (mult_field+24)`. On failure `res_freq` is 0. No write follows a failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_freq | input | FREQ_W | External reference frequency in Hz |
| req_gain | input | 8 | Gain select, nonzero means high gain |
| req_xtal | input | 1 | 1 = crystal oscillator, 0 = external clock |
| req_pdiv | input | 8 | PLL pre-divider |
| req_mult | input | 8 | PLL multiplier |
| req_engage | input | 1 | Switch the system clock to the PLL at the end |
| st_clk | input | 2 | Clock-source status (0 FLL, 2 external, 3 PLL) |
| st_iref | input | 1 | FLL reference is internal |
| st_pllsel | input | 1 | PLL-select status |
| st_osc_ready | input | 1 | Oscillator started |
| st_lock | input | 1 | PLL locked |
| wr_en | output | 1 | Register write strobe |
| wr_sel | output | 2 | Register select |
| wr_data | output | 8 | Register data |
| done | output | 1 | Sequence finished (one cycle) |
| res_ok | output | 1 | Finished successfully |
| res_err | output | 1 | Finished with an error |
| res_code | output | 8 | Error code, 0 on success |
| res_freq | output | FREQ_W | Resulting frequency in Hz |

## Verification
The bench builds the sequencer with OSC_POLLS = 16 and STEP_POLLS = 8, leaving FREQ_W at 32. The short poll limits let every timeout error be reached within a few dozen cycles, and a status-input model delays each response by a chosen number of cycles or withholds it. Full-range frequencies reach every limit check, both range values and FLL divider codes 1 through 5. The write queue and the final result are predicted from the requirements alone.

// File: rtl/pms_pkg.sv
package pms_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_WR_OSC, S_WR_SRC, S_POLL_OSC, S_POLL_EXT,
    S_WR_MON, S_WR_PDIV, S_WR_MULT, S_POLL_PSEL, S_POLL_LOCK,
    S_WR_ENG, S_POLL_ENG
  } seq_state_t;

  // register selector values seen on the write port
  localparam logic [1:0] REG_SRC  = 2'd0;
  localparam logic [1:0] REG_OSC  = 2'd1;
  localparam logic [1:0] REG_PDIV = 2'd2;
  localparam logic [1:0] REG_PLL  = 2'd3;

  localparam logic [7:0] SRC_RESET = 8'h04;

  localparam int unsigned F_EXT_MAX  = 50_000_000;
  localparam int unsigned F_XTAL_MIN = 3_000_000;
  localparam int unsigned F_XTAL_MAX = 32_000_000;
  localparam int unsigned F_REF_MIN  = 2_000_000;
  localparam int unsigned F_REF_MAX  = 4_000_000;
  localparam int unsigned F_PLL_MIN  = 48_000_000;
  localparam int unsigned F_PLL_MAX  = 100_000_000;

  localparam logic [7:0] ERR_NONE   = 8'h00;
  localparam logic [7:0] ERR_MODE   = 8'h01;
  localparam logic [7:0] ERR_FEXT   = 8'h21;
  localparam logic [7:0] ERR_FXTAL  = 8'h22;
  localparam logic [7:0] ERR_OSC    = 8'h23;
  localparam logic [7:0] ERR_EXTSEL = 8'h1A;
  localparam logic [7:0] ERR_PLLSEL = 8'h16;
  localparam logic [7:0] ERR_ENG    = 8'h1B;
  localparam logic [7:0] ERR_PDIV   = 8'h41;
  localparam logic [7:0] ERR_MULT   = 8'h42;
  localparam logic [7:0] ERR_FREF   = 8'h43;
  localparam logic [7:0] ERR_LOCK   = 8'h44;
  localparam logic [7:0] ERR_FPLL   = 8'h45;

endpackage

// File: rtl/pms_limits.sv
// Ordered range checks on a captured request; first failure wins.
module pms_limits
  import pms_pkg::*;
#(
  parameter int FREQ_W = 32
) (
  input  logic [FREQ_W-1:0] freq,
  input  logic              xtal,
  input  logic [7:0]        pdiv,
  input  logic [7:0]        mult,
  input  logic              mode_ok,
  output logic [7:0]        err
);
  localparam int PW = FREQ_W + 8;

  logic [PW-1:0] f_x, pd_x, fm;

  assign f_x  = PW'(freq);
  assign pd_x = PW'(pdiv);
  assign fm   = f_x * PW'(mult);

  // divider-free checks: scale the limits by the pre-divider instead
  always_comb begin
    err = ERR_NONE;
    if (!mode_ok)
      err = ERR_MODE;
    else if (f_x > PW'(F_EXT_MAX))
      err = ERR_FEXT;
    else if (xtal && (f_x < PW'(F_XTAL_MIN) || f_x > PW'(F_XTAL_MAX)))
      err = ERR_FXTAL;
    else if (pdiv < 8'd1 || pdiv > 8'd25)
      err = ERR_PDIV;
    else if (mult < 8'd24 || mult > 8'd55)
      err = ERR_MULT;
    else if (f_x < PW'(F_REF_MIN) * pd_x || f_x > PW'(F_REF_MAX) * pd_x)
      err = ERR_FREF;
    else if (fm < PW'(F_PLL_MIN) * pd_x || fm > PW'(F_PLL_MAX) * pd_x)
      err = ERR_FPLL;
  end
endmodule

// File: rtl/pms_encode.sv
// Field encodings derived from the request, and the final frequency.
module pms_encode #(
  parameter int FREQ_W = 32
) (
  input  logic [FREQ_W-1:0] freq,
  input  logic [7:0]        pdiv,
  input  logic [7:0]        mult,
  input  logic [4:0]        pdiv_fld,
  input  logic [4:0]        mult_fld,
  output logic [1:0]        range,
  output logic [2:0]        fll_div,
  output logic [4:0]        pdiv_code,
  output logic [4:0]        mult_code,
  output logic [FREQ_W-1:0] out_freq
);
  logic [5:0] pd_val, mu_val;

  assign range     = (freq <= FREQ_W'(3_000_000)) ? 2'd1 : 2'd2;
  assign pdiv_code = pdiv[4:0] - 5'd1;
  assign mult_code = 5'(mult - 8'd24);

  always_comb begin
    if      (freq <= FREQ_W'(1_250_000))  fll_div = 3'd0;
    else if (freq <= FREQ_W'(2_500_000))  fll_div = 3'd1;
    else if (freq <= FREQ_W'(5_000_000))  fll_div = 3'd2;
    else if (freq <= FREQ_W'(10_000_000)) fll_div = 3'd3;
    else if (freq <= FREQ_W'(20_000_000)) fll_div = 3'd4;
    else                                  fll_div = 3'd5;
  end

  // result rebuilt from the field values actually written
  assign pd_val   = {1'b0, pdiv_fld} + 6'd1;
  assign mu_val   = {1'b0, mult_fld} + 6'd24;
  assign out_freq = (freq / FREQ_W'(pd_val)) * FREQ_W'(mu_val);
endmodule

// File: rtl/pms_timer.sv
// Poll attempt counter; restarts whenever the sequencer changes state.
module pms_timer #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (restart || !run)  cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  assign last = run && (cnt == limit - 1'b1);
endmodule

// File: rtl/pll_mode_sequencer.sv
module pll_mode_sequencer
  import pms_pkg::*;
#(
  parameter int FREQ_W     = 32,
  parameter int OSC_POLLS  = 10000,
  parameter int STEP_POLLS = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [FREQ_W-1:0] req_freq,
  input  logic [7:0]        req_gain,
  input  logic              req_xtal,
  input  logic [7:0]        req_pdiv,
  input  logic [7:0]        req_mult,
  input  logic              req_engage,
  input  logic [1:0]        st_clk,
  input  logic              st_iref,
  input  logic              st_pllsel,
  input  logic              st_osc_ready,
  input  logic              st_lock,
  output logic              wr_en,
  output logic [1:0]        wr_sel,
  output logic [7:0]        wr_data,
  output logic              done,
  output logic              res_ok,
  output logic              res_err,
  output logic [7:0]        res_code,
  output logic [FREQ_W-1:0] res_freq
);
  localparam int MAX_POLLS = (OSC_POLLS > STEP_POLLS) ? OSC_POLLS : STEP_POLLS;
  localparam int CNT_W     = $clog2(MAX_POLLS + 1);

  seq_state_t st, nxt;

  logic [FREQ_W-1:0] f_q;
  logic              gain_q, xtal_q, eng_q;
  logic [7:0]        pd_q, mu_q;
  logic [7:0]        sh_src, sh_osc, sh_pdiv, sh_pll;

  logic [7:0]        chk_err;
  logic [1:0]        range;
  logic [2:0]        fll_div;
  logic [4:0]        pd_code, mu_code;
  logic [FREQ_W-1:0] fin_freq;
  logic              poll_run, poll_last;
  logic [CNT_W-1:0]  poll_lim;
  logic              fin_ok, fin_err;
  logic [7:0]        fin_code;

  pms_limits #(.FREQ_W(FREQ_W)) u_limits (
    .freq(f_q), .xtal(xtal_q), .pdiv(pd_q), .mult(mu_q),
    .mode_ok(st_clk == 2'd0 && st_iref && !st_pllsel),
    .err(chk_err)
  );

  pms_encode #(.FREQ_W(FREQ_W)) u_encode (
    .freq(f_q), .pdiv(pd_q), .mult(mu_q),
    .pdiv_fld(sh_pdiv[4:0]), .mult_fld(sh_pll[4:0]),
    .range(range), .fll_div(fll_div), .pdiv_code(pd_code),
    .mult_code(mu_code), .out_freq(fin_freq)
  );

  pms_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(poll_run), .restart(nxt != st),
    .limit(poll_lim), .last(poll_last)
  );

  assign req_ready = (st == S_IDLE);

  always_comb begin
    nxt      = st;
    wr_en    = 1'b0;
    wr_sel   = REG_SRC;
    wr_data  = 8'h00;
    poll_run = 1'b0;
    poll_lim = CNT_W'(STEP_POLLS);
    fin_ok   = 1'b0;
    fin_err  = 1'b0;
    fin_code = ERR_NONE;
    case (st)
      S_IDLE:  if (req_valid) nxt = S_CHECK;
      S_CHECK: begin
        if (chk_err != ERR_NONE) begin fin_err = 1'b1; fin_code = chk_err; end
        else nxt = S_WR_OSC;
      end
      S_WR_OSC: begin
        wr_en = 1'b1; wr_sel = REG_OSC;
        wr_data = {sh_osc[7:6], range, gain_q, xtal_q, sh_osc[1:0]};
        nxt = S_WR_SRC;
      end
      S_WR_SRC: begin
        wr_en = 1'b1; wr_sel = REG_SRC;
        wr_data = {2'd2, fll_div, 1'b0, sh_src[1:0]};
        nxt = xtal_q ? S_POLL_OSC : S_POLL_EXT;
      end
      S_POLL_OSC: begin
        poll_run = 1'b1; poll_lim = CNT_W'(OSC_POLLS);
        if (st_osc_ready) nxt = S_POLL_EXT;
        else if (poll_last) begin fin_err = 1'b1; fin_code = ERR_OSC; end
      end
      S_POLL_EXT: begin
        poll_run = 1'b1;
        if (st_clk == 2'd2) nxt = S_WR_MON;
        else if (poll_last) begin fin_err = 1'b1; fin_code = ERR_EXTSEL; end
      end
      S_WR_MON: begin
        wr_en = 1'b1; wr_sel = REG_PLL; wr_data = sh_pll | 8'h20;
        nxt = S_WR_PDIV;
      end
      S_WR_PDIV: begin
        wr_en = 1'b1; wr_sel = REG_PDIV; wr_data = {sh_pdiv[7:5], pd_code};
        nxt = S_WR_MULT;
      end
      S_WR_MULT: begin
        wr_en = 1'b1; wr_sel = REG_PLL; wr_data = {1'b1, sh_pll[6:5], mu_code};
        nxt = S_POLL_PSEL;
      end
      S_POLL_PSEL: begin
        poll_run = 1'b1;
        if (st_pllsel) nxt = S_POLL_LOCK;
        else if (poll_last) begin fin_err = 1'b1; fin_code = ERR_PLLSEL; end
      end
      S_POLL_LOCK: begin
        poll_run = 1'b1;
        if (st_lock) begin
          if (eng_q) nxt = S_WR_ENG;
          else fin_ok = 1'b1;
        end else if (poll_last) begin fin_err = 1'b1; fin_code = ERR_LOCK; end
      end
      S_WR_ENG: begin
        wr_en = 1'b1; wr_sel = REG_SRC; wr_data = {2'd0, sh_src[5:0]};
        nxt = S_POLL_ENG;
      end
      S_POLL_ENG: begin
        poll_run = 1'b1;
        if (st_clk == 2'd3) fin_ok = 1'b1;
        else if (poll_last) begin fin_err = 1'b1; fin_code = ERR_ENG; end
      end
      default: nxt = S_IDLE;
    endcase
    if (fin_ok || fin_err) nxt = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      f_q <= '0; gain_q <= 1'b0; xtal_q <= 1'b0; eng_q <= 1'b0;
      pd_q <= '0; mu_q <= '0;
    end else begin
      st <= nxt;
      if (st == S_IDLE && req_valid) begin
        f_q    <= req_freq;
        gain_q <= |req_gain;
        xtal_q <= req_xtal;
        pd_q   <= req_pdiv;
        mu_q   <= req_mult;
        eng_q  <= req_engage;
      end
    end
  end

  // shadow copies for read-modify-write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_src <= SRC_RESET; sh_osc <= '0; sh_pdiv <= '0; sh_pll <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        REG_SRC:  sh_src  <= wr_data;
        REG_OSC:  sh_osc  <= wr_data;
        REG_PDIV: sh_pdiv <= wr_data;
        default:  sh_pll  <= wr_data;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0; res_ok <= 1'b0; res_err <= 1'b0;
      res_code <= '0; res_freq <= '0;
    end else begin
      done    <= fin_ok | fin_err;
      res_ok  <= fin_ok;
      res_err <= fin_err;
      if (fin_ok || fin_err) begin
        res_code <= fin_code;
        res_freq <= fin_ok ? fin_freq : '0;
      end
    end
  end
endmodule

// File: rtl/pms_props.sv
module pms_props #(
  parameter int FREQ_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              wr_en,
  input logic              done,
  input logic              res_ok,
  input logic              res_err,
  input logic [7:0]        res_code,
  input logic [FREQ_W-1:0] res_freq
);
  // R12
  done_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (res_ok ^ res_err));

  // R12
  flag_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_ok || res_err) |-> done);

  // R12
  ok_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_ok |-> (res_code == 8'h00 && res_freq != '0));

  // R12
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(res_code) && $stable(res_freq)));

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R1
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !req_ready);

  // R12
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind pll_mode_sequencer pms_props #(.FREQ_W(FREQ_W)) u_props (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .wr_en(wr_en), .done(done), .res_ok(res_ok), .res_err(res_err),
  .res_code(res_code), .res_freq(res_freq)
);

// File: tb/pll_mode_sequencer_bench.sv
module pll_mode_sequencer_bench;
  localparam int FW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req_valid = 1'b0, req_xtal = 1'b0, req_engage = 1'b0;
  logic          req_ready;
  logic [FW-1:0] req_freq = '0;
  logic [7:0]    req_gain = '0, req_pdiv = '0, req_mult = '0;
  logic [1:0]    st_clk = 2'd0;
  logic          st_iref = 1'b1, st_pllsel = 1'b0, st_osc_ready = 1'b0, st_lock = 1'b0;
  logic          wr_en, done, res_ok, res_err;
  logic [1:0]    wr_sel;
  logic [7:0]    wr_data, res_code;
  logic [FW-1:0] res_freq;

  pll_mode_sequencer #(.FREQ_W(FW), .OSC_POLLS(16), .STEP_POLLS(8)) u_pll_mode_sequencer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_freq(req_freq), .req_gain(req_gain), .req_xtal(req_xtal),
    .req_pdiv(req_pdiv), .req_mult(req_mult), .req_engage(req_engage),
    .st_clk(st_clk), .st_iref(st_iref), .st_pllsel(st_pllsel),
    .st_osc_ready(st_osc_ready), .st_lock(st_lock),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .done(done), .res_ok(res_ok), .res_err(res_err),
    .res_code(res_code), .res_freq(res_freq)
  );

  int checks = 0, errors = 0;
  string cur_req = "R1";

  task automatic check_eq(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---- status-input plant: delays in cycles, negative means never ----
  int  d_osc, d_ext, d_psel, d_lock, d_eng;
  int  c_osc = -1, c_ext = -1, c_psel = -1, c_lock = -1, c_eng = -1;
  bit  plant_clr = 1'b0, bad_mode = 1'b0;

  always @(posedge clk) begin
    if (plant_clr) begin
      st_clk <= bad_mode ? 2'd1 : 2'd0;
      st_iref <= 1'b1; st_pllsel <= 1'b0; st_osc_ready <= 1'b0; st_lock <= 1'b0;
      c_osc <= -1; c_ext <= -1; c_psel <= -1; c_lock <= -1; c_eng <= -1;
    end else begin
      if (wr_en && wr_sel == 2'd0 && wr_data[7:6] == 2'd2) begin
        c_osc <= d_osc; c_ext <= d_ext;
      end else begin
        if (c_osc > 0) c_osc <= c_osc - 1;
        else if (c_osc == 0) begin st_osc_ready <= 1'b1; c_osc <= -1; end
        if (c_ext > 0) c_ext <= c_ext - 1;
        else if (c_ext == 0) begin st_clk <= 2'd2; c_ext <= -1; end
      end
      if (wr_en && wr_sel == 2'd3 && wr_data[7]) c_psel <= d_psel;
      else if (c_psel > 0) c_psel <= c_psel - 1;
      else if (c_psel == 0) begin st_pllsel <= 1'b1; c_psel <= -1; c_lock <= d_lock; end
      if (c_lock > 0) c_lock <= c_lock - 1;
      else if (c_lock == 0) begin st_lock <= 1'b1; c_lock <= -1; end
      if (wr_en && wr_sel == 2'd0 && wr_data[7:6] == 2'd0) c_eng <= d_eng;
      else if (c_eng > 0) c_eng <= c_eng - 1;
      else if (c_eng == 0) begin st_clk <= 2'd3; c_eng <= -1; end
    end
  end

  // ---- reference model state ----
  logic [9:0] exp_q[$];
  int  m_src = 8'h04, m_osc = 0, m_pdiv = 0, m_pll = 0;
  int  exp_code;
  longint exp_freq;
  bit  busy = 1'b0, done_seen = 1'b0, mon_on = 1'b0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (wr_en) begin
        if (exp_q.size() == 0)
          check_eq(cur_req, "unexpected write", {wr_sel, wr_data}, 10'h3ff);
        else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          check_eq(cur_req, "write sel/data", {wr_sel, wr_data}, e);
        end
      end
      if (done) begin
        check_eq(cur_req, "res_code", res_code, exp_code);
        check_eq(cur_req, "res_ok", res_ok, exp_code == 0);
        check_eq(cur_req, "res_err", res_err, exp_code != 0);
        check_eq(cur_req, "res_freq", res_freq, exp_freq);
        check_eq(cur_req, "missing writes", exp_q.size(), 0);
        busy = 1'b0;
        done_seen = 1'b1;
      end
      check_eq("R1", "req_ready", req_ready, !busy);
    end
  end

  function automatic int fll_code(longint f);
    if (f <= 1250000) return 0;
    if (f <= 2500000) return 1;
    if (f <= 5000000) return 2;
    if (f <= 10000000) return 3;
    if (f <= 20000000) return 4;
    return 5;
  endfunction

  task automatic run_case(string req, longint f, int g, bit x, int pd, int mu, bit eng,
                          bit bad, int dosc, int dext, int dpsel, int dlock, int deng,
                          bit poke);
    int code;
    cur_req = req;
    d_osc = dosc; d_ext = dext; d_psel = dpsel; d_lock = dlock; d_eng = deng;
    bad_mode = bad;
    @(negedge clk) plant_clr = 1'b1;
    @(negedge clk) plant_clr = 1'b0;
    code = 0;
    if (bad) code = 8'h01;
    else if (f > 50000000) code = 8'h21;
    else if (x && (f < 3000000 || f > 32000000)) code = 8'h22;
    else if (pd < 1 || pd > 25) code = 8'h41;
    else if (mu < 24 || mu > 55) code = 8'h42;
    else if (f < 64'd2000000 * pd || f > 64'd4000000 * pd) code = 8'h43;
    else if (f * mu < 64'd48000000 * pd || f * mu > 64'd100000000 * pd) code = 8'h45;
    if (code == 0) begin
      m_osc = (m_osc & 8'hC3) | ((f <= 3000000 ? 1 : 2) << 4) | ((g != 0) << 3) | (x << 2);
      exp_q.push_back({2'd1, 8'(m_osc)});
      m_src = (m_src & 8'h03) | (2 << 6) | (fll_code(f) << 3);
      exp_q.push_back({2'd0, 8'(m_src)});
      if (x && dosc < 0) code = 8'h23;
      else if (dext < 0) code = 8'h1A;
    end
    if (code == 0) begin
      m_pll = m_pll | 8'h20;
      exp_q.push_back({2'd3, 8'(m_pll)});
      m_pdiv = (m_pdiv & 8'hE0) | (pd - 1);
      exp_q.push_back({2'd2, 8'(m_pdiv)});
      m_pll = (m_pll & 8'h60) | 8'h80 | (mu - 24);
      exp_q.push_back({2'd3, 8'(m_pll)});
      if (dpsel < 0) code = 8'h16;
      else if (dlock < 0) code = 8'h44;
      else if (eng) begin
        m_src = m_src & 8'h3F;
        exp_q.push_back({2'd0, 8'(m_src)});
        if (deng < 0) code = 8'h1B;
      end
    end
    exp_code = code;
    exp_freq = (code == 0) ? (f / pd) * mu : 0;
    done_seen = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_freq = FW'(f); req_gain = 8'(g); req_xtal = x;
    req_pdiv = 8'(pd); req_mult = 8'(mu); req_engage = eng;
    @(posedge clk);
    busy = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      // R1: requests during a sequence must be dropped
      for (int k = 0; k < 3; k++) begin
        req_valid = 1'b1; req_freq = 32'd4000000; req_pdiv = 8'd0; req_mult = 8'd99;
        @(negedge clk);
      end
      req_valid = 1'b0;
    end
    for (int k = 0; k < 400 && !done_seen; k++) @(negedge clk);
    check_eq(req, "done observed", done_seen, 1);
    busy = 1'b0;
    exp_q.delete();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check_eq("R1", "reset req_ready", req_ready, 1);
    check_eq("R12", "reset done", done, 0);
    check_eq("R6", "reset wr_en", wr_en, 0);
    @(negedge clk) rst_n = 1'b1;
    mon_on = 1'b1;
    // successful runs and encodings
    run_case("R9",  8000000,  5, 1, 2, 24, 1, 0, 2, 2, 2, 2, 2, 0);
    run_case("R11", 50000000, 0, 0, 25, 48, 0, 0, 2, 2, 2, 2, 2, 0);
    run_case("R7",  3000000,  0, 0, 1, 32, 1, 0, 2, 2, 2, 2, 2, 0);
    run_case("R7",  2500000,  1, 0, 1, 40, 1, 0, 2, 2, 2, 2, 2, 0);
    run_case("R7",  20000000, 0, 0, 5, 25, 1, 0, 2, 2, 2, 2, 2, 0);
    run_case("R6",  32000000, 0, 1, 8, 24, 1, 0, 3, 1, 3, 1, 3, 0);
    run_case("R12", 12000000, 2, 0, 4, 30, 1, 0, 2, 2, 2, 2, 2, 0);
    // start-mode and limit checks
    run_case("R2",  8000000,  0, 1, 2, 24, 1, 1, 2, 2, 2, 2, 2, 0);
    run_case("R3",  50000001, 0, 0, 25, 48, 1, 0, 2, 2, 2, 2, 2, 0);
    run_case("R5",  50000001, 0, 1, 0, 99, 1, 0, 2, 2, 2, 2, 2, 0);
    run_case("R3",  2500000,  0, 1, 1, 40, 1, 0, 2, 2, 2, 2, 2, 0);
    run_case("R3",  32000001, 0, 1, 10, 24, 1, 0, 2, 2, 2, 2, 2, 0);
    run_case("R4",  8000000,  0, 0, 0, 24, 1, 0, 2, 2, 2, 2, 2, 0);
    run_case("R4",  8000000,  0, 0, 26, 24, 1, 0, 2, 2, 2, 2, 2, 0);
    run_case("R4",  8000000,  0, 0, 2, 23, 1, 0, 2, 2, 2, 2, 2, 0);
    run_case("R4",  8000000,  0, 0, 2, 56, 1, 0, 2, 2, 2, 2, 2, 0);
    run_case("R5",  8000000,  0, 0, 0, 56, 1, 0, 2, 2, 2, 2, 2, 0);
    run_case("R5",  10000000, 0, 0, 2, 24, 1, 0, 2, 2, 2, 2, 2, 0);
    run_case("R5",  4000000,  0, 0, 1, 26, 1, 0, 2, 2, 2, 2, 2, 0);
    // poll timeouts
    run_case("R8",  8000000,  1, 1, 2, 24, 1, 0, -1, 2, 2, 2, 2, 0);
    run_case("R8",  8000000,  0, 0, 2, 24, 1, 0, 2, -1, 2, 2, 2, 0);
    run_case("R10", 8000000,  0, 0, 2, 24, 1, 0, 2, 2, -1, 2, 2, 0);
    run_case("R10", 8000000,  0, 0, 2, 24, 1, 0, 2, 2, 2, -1, 2, 0);
    run_case("R11", 8000000,  0, 0, 2, 24, 1, 0, 2, 2, 2, 2, -1, 0);
    // ignored request while busy
    run_case("R1",  16000000, 0, 1, 4, 25, 1, 0, 4, 4, 4, 4, 4, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule